// File: doc/BRIEF.md
# Indexed Register Access Port

This block is the host-facing register port of a display pixel processor. A host selects one of eight direct locations with a 3-bit select bus and moves a byte at a time with separate read and write strobes. The direct locations include an index-control byte, the two bytes of a 16-bit index pointer, a data window into a 64K-address indexed register space, and a read-only palette address location.

Indexed registers are reached by loading the pointer, low and high bytes each through its own select code, and then reading or writing the data window. When the auto-advance bit in the index-control byte is set, the pointer steps by one after every access to the data window. With the bit clear, the pointer holds its value. The indexed space implemented here holds one register, a miscellaneous control byte. Its bits drive the block's control outputs, the format of palette address reads, and the enable and source of the sense output.

Top module: `idx_regport`

## Requirements
- R1: After reset the index pointer reads 0x0000, the index-control byte reads 0x00, the miscellaneous control byte is 0x00 (all exported controls low) and the sense output is enabled.
- R2: Select code 3'b111 reads and writes the index-control byte. Only bit 0 (auto-advance enable) is stored. Bits 7..1 read as zero and ignore writes.
- R3: Select code 3'b100 reads and writes the index low byte (bits 7..0) and 3'b101 the high byte (bits 15..8), each without changing the other.
- R4: With auto-advance off, reads and writes of the data window (select code 3'b110) leave the index pointer unchanged.
- R5: With auto-advance on, each clock with a data-window read or write strobe adds one to the pointer at that clock edge. A data access in the very next cycle uses the new index.
- R6: The pointer steps as one 16-bit value. 0x00FF steps to 0x0100 and 0xFFFF wraps to 0x0000.
- R7: The miscellaneous control byte sits at index 0x0070 and is readable and writable through the data window. Its bits 2..1 are reserved: they read as zero and ignore writes.
- R8: At any index other than 0x0070 the data window reads 0x00 and writes have no effect. Such accesses still advance the pointer when auto-advance is on.
- R9: A read of select code 3'b011 returns the 8-bit palette read address when miscellaneous bit 5 is 0. When bit 5 is 1, it returns the 2-bit palette access state in bits 1..0 with zeros above.
- R10: Miscellaneous bit 4 set turns the sense output off (sense_oe low). Bit 3 picks the sense source: 0 selects the unlatched sense bit, 1 selects the latched one.
- R11: Miscellaneous bits 7, 6 and 0 appear directly on the signature-enable, mask-enable and wide-bus outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 3 | Direct register select |
| wr_en | input | 1 | Write strobe, one byte per clock |
| rd_en | input | 1 | Read strobe, one byte per clock |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle, zero otherwise |
| pal_rd_addr | input | 8 | Palette read address from the palette logic |
| pal_state | input | 2 | Palette access state from the palette logic |
| sense_unl | input | 1 | Unlatched sense bit |
| sense_lat | input | 1 | Latched sense bit |
| sense_out | output | 1 | Selected sense bit |
| sense_oe | output | 1 | Sense driver enable |
| sig_en | output | 1 | Signature accumulation enable (misc bit 7) |
| mask_en | output | 1 | Pixel input masking enable (misc bit 6) |
| pal_fmt | output | 1 | Palette address read format (misc bit 5) |
| wide_bus | output | 1 | 64-bit pixel bus select (misc bit 0) |

## Verification
Read data is combinational, so it is sampled in the same cycle as the read strobe, mid-cycle after the falling edge that drove it. Register writes, pointer steps and the exported controls change at the rising edge that ends the strobe cycle, so the bench looks for them no earlier than the following cycle, through a later read or after an idle cycle. Back-to-back data-window reads are issued on consecutive cycles to show that the second one already sees the stepped pointer.

// File: rtl/idxp_pkg.sv
package idxp_pkg;
  localparam int DW = 8;
  localparam int IW = 2 * DW;

  localparam logic [2:0] SEL_PAL = 3'b011;
  localparam logic [2:0] SEL_ILO = 3'b100;
  localparam logic [2:0] SEL_IHI = 3'b101;
  localparam logic [2:0] SEL_DAT = 3'b110;
  localparam logic [2:0] SEL_CTL = 3'b111;

  // storable bits of the miscellaneous control byte (2..1 reserved)
  localparam logic [DW-1:0] MISC_KEEP = 8'hF9;

  // pointer advance: one 16-bit step, wrapping at the top
  function automatic logic [IW-1:0] idx_step(input logic [IW-1:0] v);
    return v + {{(IW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DW-1:0] keep_bits(input logic [DW-1:0] d,
                                              input logic [DW-1:0] m);
    return d & m;
  endfunction
endpackage

// File: rtl/idx_pointer.sv
module idx_pointer
  import idxp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic          ctl_we,
  input  logic          data_acc,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] index,
  output logic          inc_en
);
  logic          step_now;
  logic [IW-1:0] index_nx;

  assign step_now = data_acc && inc_en;
  assign index_nx = idx_step(index);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_en <= 1'b0;
    end else if (ctl_we) begin
      inc_en <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index <= '0;
    end else if (lo_we) begin
      index[DW-1:0] <= wdata;
    end else if (hi_we) begin
      index[IW-1:DW] <= wdata;
    end else if (step_now) begin
      index <= index_nx;
    end
  end

  // R5: an enabled data access steps the pointer by one at that edge
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && inc_en && !lo_we && !hi_we) |=> (index == $past(index) + 16'd1));

  // R4: with auto-advance off a data access leaves the pointer alone
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !inc_en && !lo_we && !hi_we) |=> $stable(index));

  // R6: top of the range wraps to zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && inc_en && index == 16'hFFFF) |=> (index == 16'h0000));
endmodule

// File: rtl/idx_space.sv
module idx_space
  import idxp_pkg::*;
#(
  parameter logic [IW-1:0] MISC_ADDR = 16'h0070
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] index,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] misc
);
  logic hit_misc;

  assign hit_misc = (index == MISC_ADDR);
  assign rd_val   = hit_misc ? misc : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc <= '0;
    end else if (data_we && hit_misc) begin
      misc <= keep_bits(wdata, MISC_KEEP);
    end
  end

  // R8: a write to any other index leaves the control byte untouched
  a_r8_no_side: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !hit_misc) |=> $stable(misc));
endmodule

// File: rtl/sense_ctl.sv
module sense_ctl (
  input  logic dis,
  input  logic pick_lat,
  input  logic sense_unl,
  input  logic sense_lat,
  output logic sense_out,
  output logic sense_oe
);
  assign sense_oe  = !dis;
  assign sense_out = pick_lat ? sense_lat : sense_unl;
endmodule

// File: rtl/idx_regport.sv
module idx_regport
  import idxp_pkg::*;
#(
  parameter logic [15:0] MISC_ADDR = 16'h0070
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pal_rd_addr,
  input  logic [1:0] pal_state,
  input  logic       sense_unl,
  input  logic       sense_lat,
  output logic       sense_out,
  output logic       sense_oe,
  output logic       sig_en,
  output logic       mask_en,
  output logic       pal_fmt,
  output logic       wide_bus
);
  logic          lo_we, hi_we, ctl_we, data_we, data_acc;
  logic [IW-1:0] index;
  logic          inc_en;
  logic [DW-1:0] space_rd, misc;
  logic [DW-1:0] pal_view, rd_mux;

  assign lo_we    = wr_en && (sel == SEL_ILO);
  assign hi_we    = wr_en && (sel == SEL_IHI);
  assign ctl_we   = wr_en && (sel == SEL_CTL);
  assign data_we  = wr_en && (sel == SEL_DAT);
  assign data_acc = (wr_en || rd_en) && (sel == SEL_DAT);

  idx_pointer u_ptr (
    .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we), .ctl_we(ctl_we),
    .data_acc(data_acc), .wdata(wdata), .index(index), .inc_en(inc_en)
  );

  idx_space #(.MISC_ADDR(MISC_ADDR)) u_space (
    .clk(clk), .rst_n(rst_n), .index(index), .data_we(data_we),
    .wdata(wdata), .rd_val(space_rd), .misc(misc)
  );

  sense_ctl u_sense (
    .dis(misc[4]), .pick_lat(misc[3]), .sense_unl(sense_unl),
    .sense_lat(sense_lat), .sense_out(sense_out), .sense_oe(sense_oe)
  );

  assign sig_en   = misc[7];
  assign mask_en  = misc[6];
  assign pal_fmt  = misc[5];
  assign wide_bus = misc[0];

  assign pal_view = pal_fmt ? {6'b0, pal_state} : pal_rd_addr;

  always_comb begin
    case (sel)
      SEL_PAL: rd_mux = pal_view;
      SEL_ILO: rd_mux = index[DW-1:0];
      SEL_IHI: rd_mux = index[IW-1:DW];
      SEL_DAT: rd_mux = space_rd;
      SEL_CTL: rd_mux = {7'b0, inc_en};
      default: rd_mux = '0;
    endcase
  end

  assign rdata = rd_en ? rd_mux : '0;

  // R2: reserved control bits never show on a read
  a_r2_ctl_resv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_CTL) |-> (rdata[7:1] == 7'b0));

  // R8: unimplemented indexed addresses read as zero
  a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_DAT && index != MISC_ADDR) |-> (rdata == 8'h00));

  // R7: reserved control-byte bits never show on a read
  a_r7_misc_resv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_DAT) |-> (rdata[2:1] == 2'b0));

  // R9: state format keeps the upper six bits clear
  a_r9_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_PAL && pal_fmt) |-> (rdata[7:2] == 6'b0));
endmodule

// File: tb/idx_regport_tb.sv
module idx_regport_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic [7:0] pal_rd_addr = 8'hC6;
  logic [1:0] pal_state = 2'b10;
  logic       sense_unl = 1'b1, sense_lat = 1'b0;
  logic       sense_out, sense_oe, sig_en, mask_en, pal_fmt, wide_bus;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = !clk;

  idx_regport u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pal_rd_addr(pal_rd_addr),
    .pal_state(pal_state), .sense_unl(sense_unl), .sense_lat(sense_lat),
    .sense_out(sense_out), .sense_oe(sense_oe), .sig_en(sig_en),
    .mask_en(mask_en), .pal_fmt(pal_fmt), .wide_bus(wide_bus)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // each op starts at a falling edge and ends at the next one
  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    sel = s; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    sel = s; rd_en = 1'b1; wr_en = 1'b0;
    #5 v = rdata;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic get_index(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'b100, lo); rd(3'b101, hi); idle();
    v = {hi, lo};
  endtask

  task automatic set_index(input logic [15:0] v);
    wr(3'b100, v[7:0]); wr(3'b101, v[15:8]); idle();
  endtask

  task automatic set_misc(input logic [7:0] v);
    wr(3'b111, 8'h00); set_index(16'h0070); wr(3'b110, v); idle();
  endtask

  task automatic t_reset();
    logic [7:0] v; logic [15:0] ix;
    rd(3'b111, v); idle(); chk("R1 ctl", v, 0);
    get_index(ix); chk("R1 index", ix, 0);
    chk("R1 exports", {sig_en, mask_en, pal_fmt, wide_bus}, 0);
    chk("R1 sense_oe", sense_oe, 1);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(3'b111, 8'hFF); rd(3'b111, v); idle(); chk("R2 reserved", v, 8'h01);
    wr(3'b111, 8'hFE); rd(3'b111, v); idle(); chk("R2 clear", v, 8'h00);
  endtask

  task automatic t_index();
    logic [15:0] ix;
    set_index(16'h3C5A); get_index(ix); chk("R3 both", ix, 16'h3C5A);
    wr(3'b101, 8'hAB); idle(); get_index(ix); chk("R3 high only", ix, 16'hAB5A);
  endtask

  task automatic t_noinc();
    logic [7:0] v; logic [15:0] ix;
    set_misc(8'hFF); get_index(ix); chk("R4 after write", ix, 16'h0070);
    rd(3'b110, v); rd(3'b110, v); idle();
    chk("R7 reserved bits", v, 8'hF9);
    get_index(ix); chk("R4 after reads", ix, 16'h0070);
  endtask

  task automatic t_inc();
    logic [7:0] a, b; logic [15:0] ix;
    wr(3'b111, 8'h01); set_index(16'h006F);
    rd(3'b110, a); rd(3'b110, b); idle();
    chk("R8 unimpl read", a, 8'h00);
    chk("R5 back-to-back", b, 8'hF9);
    get_index(ix); chk("R5 two steps", ix, 16'h0071);
  endtask

  task automatic t_wrap();
    logic [7:0] v; logic [15:0] ix;
    wr(3'b111, 8'h01);
    set_index(16'h00FF); wr(3'b110, 8'h00); idle();
    get_index(ix); chk("R6 carry", ix, 16'h0100);
    set_index(16'hFFFF); rd(3'b110, v); idle();
    get_index(ix); chk("R6 wrap", ix, 16'h0000);
  endtask

  task automatic t_unimpl();
    logic [15:0] ix;
    set_misc(8'h00);
    wr(3'b111, 8'h01); set_index(16'h1234); wr(3'b110, 8'hFF); idle();
    get_index(ix); chk("R8 step", ix, 16'h1235);
    chk("R8 no side effect", {sig_en, mask_en, pal_fmt, wide_bus, sense_oe}, 5'b00001);
  endtask

  task automatic t_pal();
    logic [7:0] v;
    set_misc(8'h00); rd(3'b011, v); idle(); chk("R9 address", v, 8'hC6);
    set_misc(8'h20); rd(3'b011, v); idle(); chk("R9 state", v, 8'h02);
  endtask

  task automatic t_sense();
    set_misc(8'h00); chk("R10 unlatched", {sense_oe, sense_out}, 2'b11);
    set_misc(8'h08); chk("R10 latched", {sense_oe, sense_out}, 2'b10);
    set_misc(8'h10); chk("R10 disabled", sense_oe, 0);
  endtask

  task automatic t_export();
    set_misc(8'h81); chk("R11 sig/wide", {sig_en, mask_en, wide_bus}, 3'b101);
    set_misc(8'h40); chk("R11 mask", {sig_en, mask_en, wide_bus}, 3'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_ctrl(); t_index(); t_noinc(); t_inc();
    t_wrap(); t_unimpl(); t_pal(); t_sense(); t_export();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule